// File: doc/BRIEF.md
# Dual-Issue Instruction Dispatch Unit

This block sits between an instruction fetcher and a set of execution units. Fetch hands it up to four pre-decoded instruction records per cycle. It keeps them in order in a small shifting instruction queue. Each cycle it decides which of the oldest records leave for an integer, floating-point, system-register or load/store unit, and whether a branch leaves on a separate branch lane. At most two non-branch records and one branch go out per cycle, so up to three dispatches can happen in one cycle.

Dispatch is combinational from the registered queue. A lane's valid output rises only in a cycle when the target unit reports ready. The receiving unit captures the record at the next rising edge. For each source register the block sends the register value when that register is not pending. When the register is pending, it sends the tag of the rename register that will produce the value. Every dispatched record uses one completion-queue slot, and the block never uses more slots than the completion queue reports free.

Top module: `dual_issue_dispatch`

## Requirements
- R1: The instruction queue holds IQ_DEPTH records. Each cycle, `fetchTake` equals min(`fetchNum`, IQ_DEPTH minus the occupancy at the start of the cycle). Records `fetchRecs[0..fetchTake-1]` are appended behind the older records. A record is 17 bits: bit 16 is the branch flag, bits 15:14 the unit (0 integer, 1 floating-point, 2 system-register, 3 load/store), bits 13:6 the opcode, bits 5:3 source A and bits 2:0 source B.
- R2: A non-branch record dispatches only from queue position 0 or 1, and always on lane 0 or lane 1 respectively.
- R3: Dispatch is in program order. The records dispatched in a cycle are exactly queue positions 0 up to n-1. A record that cannot go blocks every younger record.
- R4: At most one branch dispatches per cycle. It may come from position 0, 1 or 2, leaves on the branch lane, and needs `brReady`.
- R5: A non-branch record needs `unitReady[unit]`. When two non-branch records target the same unit, only the older one goes.
- R6: The number dispatched in a cycle, reported on `cqAllocCount`, never exceeds `cqFreeCount`.
- R7: The k-th record dispatched in a cycle (k counted from 0 in program order) carries completion index (`cqTail` + k) mod CQ_DEPTH.
- R8: For each source register r, if `rfPending[r]` is 0, the output has ready = 1, value = `rfValue[r]` and tag = 0. Otherwise the output has ready = 0, value = 0 and tag = `rfTag[r]`.
- R9: After reset the queue is empty. No lane or branch dispatch occurs, and the full fetch group is accepted.
- R10: After n records dispatch, the remaining records move down n positions with their order unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| fetchNum | input | 3 | Number of valid records offered by fetch (0..4) |
| fetchRecs | input | 4x17 | Offered records, oldest at index 0 |
| fetchTake | output | 3 | Number of offered records accepted this cycle |
| unitReady | input | 4 | Per execution unit: can take one record this cycle |
| brReady | input | 1 | Branch unit can take one record this cycle |
| cqFreeCount | input | 3 | Free completion-queue slots |
| cqTail | input | 3 | Index of the next completion slot to allocate |
| cqAllocCount | output | 2 | Completion slots claimed this cycle |
| rfValue | input | 8x16 | Register values |
| rfPending | input | 8 | Per register: value still being produced |
| rfTag | input | 8x3 | Per register: producing rename tag |
| laneValid | output | 2 | Non-branch lane dispatch strobes |
| laneUnit | output | 2x2 | Target unit per lane |
| laneOp | output | 2x8 | Opcode per lane |
| laneRdyA | output | 2 | Source A ready per lane |
| laneValA | output | 2x16 | Source A value per lane |
| laneTagA | output | 2x3 | Source A rename tag per lane |
| laneRdyB | output | 2 | Source B ready per lane |
| laneValB | output | 2x16 | Source B value per lane |
| laneTagB | output | 2x3 | Source B rename tag per lane |
| laneCq | output | 2x3 | Completion index per lane |
| brValid | output | 1 | Branch lane dispatch strobe |
| brOp | output | 8 | Branch opcode |
| brRdyA | output | 1 | Branch source A ready |
| brValA | output | 16 | Branch source A value |
| brTagA | output | 3 | Branch source A rename tag |
| brRdyB | output | 1 | Branch source B ready |
| brValB | output | 16 | Branch source B value |
| brTagB | output | 3 | Branch source B rename tag |
| brCq | output | 3 | Branch completion index |

## Verification
Dispatch from the queue head and the fetch append often happen in the same cycle. The append position then depends on how many records leave, and the fetch acceptance depends on the occupancy before the shift. The bench provokes this by offering full fetch groups in cycles of single, dual and triple dispatch. It also fills the queue by holding free completion slots at zero and then releases it. A behavioural queue in the bench predicts every lane, completion index, operand field and the accepted fetch count, and these predictions are compared in every cycle.

// File: rtl/dispatch_pkg.sv
package dispatch_pkg;
  localparam int FETCH_W   = 4;
  localparam int NUM_REGS  = 8;
  localparam int OP_W      = 8;
  localparam int NUM_UNITS = 4;
  localparam int LANES     = 2;
  localparam int HEAD_N    = LANES + 1;
  localparam int RIDX_W    = $clog2(NUM_REGS);
  localparam int FCNT_W    = $clog2(FETCH_W + 1);

  typedef enum logic [1:0] {
    UNIT_INT = 2'd0,
    UNIT_FLT = 2'd1,
    UNIT_SYS = 2'd2,
    UNIT_MEM = 2'd3
  } unitSel_t;

  typedef struct packed {
    logic              isBranch;
    unitSel_t          unit;
    logic [OP_W-1:0]   op;
    logic [RIDX_W-1:0] srcA;
    logic [RIDX_W-1:0] srcB;
  } instRec_t;

  localparam int REC_W = $bits(instRec_t);

  typedef struct packed {
    logic [1:0]        shiftBy;
    logic [FCNT_W-1:0] appendBy;
    logic [LANES-1:0]  laneFire;
    logic              brFire;
    logic [1:0]        brPos;
  } dispStrobe_t;
endpackage

// File: rtl/dispatch_ctrl.sv
module dispatch_ctrl
  import dispatch_pkg::*;
#(
  parameter int IQ_DEPTH = 8,
  parameter int CQ_DEPTH = 6,
  localparam int OCC_W = $clog2(IQ_DEPTH + 1),
  localparam int CQF_W = $clog2(CQ_DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [OCC_W-1:0]        occ,
  input  instRec_t [HEAD_N-1:0]   head,
  input  logic [FCNT_W-1:0]       fetchNum,
  input  logic [NUM_UNITS-1:0]    unitReady,
  input  logic                    brReady,
  input  logic [CQF_W-1:0]        cqFreeCount,
  output logic [FCNT_W-1:0]       fetchTake,
  output logic [1:0]              cqAllocCount,
  output dispStrobe_t             stb
);

  // Scan the oldest positions in order; the first refusal halts the scan.
  always_comb begin
    int taken;
    logic halt;
    logic brSeen;
    logic canGo;
    logic [NUM_UNITS-1:0] usedUnits;
    taken     = 0;
    halt      = 1'b0;
    brSeen    = 1'b0;
    canGo     = 1'b0;
    usedUnits = '0;
    stb.laneFire = '0;
    stb.brFire   = 1'b0;
    stb.brPos    = 2'd0;
    for (int p = 0; p < HEAD_N; p++) begin
      canGo = !halt && (p < int'(occ)) && (taken < int'(cqFreeCount));
      if (head[p].isBranch) begin
        canGo = canGo && !brSeen && brReady;
      end else begin
        canGo = canGo && (p < LANES) && unitReady[head[p].unit]
                && !usedUnits[head[p].unit];
      end
      if (canGo) begin
        taken = taken + 1;
        if (head[p].isBranch) begin
          brSeen     = 1'b1;
          stb.brFire = 1'b1;
          stb.brPos  = 2'(p);
        end else begin
          usedUnits[head[p].unit] = 1'b1;
          if (p == 0) stb.laneFire[0] = 1'b1;
          else        stb.laneFire[1] = 1'b1;
        end
      end else begin
        halt = 1'b1;
      end
    end
    stb.shiftBy  = 2'(taken);
    cqAllocCount = 2'(taken);
  end

  // Fetch acceptance uses the occupancy held at the start of the cycle.
  always_comb begin
    int space;
    int offered;
    space   = IQ_DEPTH - int'(occ);
    offered = (int'(fetchNum) > FETCH_W) ? FETCH_W : int'(fetchNum);
    fetchTake    = FCNT_W'((offered < space) ? offered : space);
    stb.appendBy = fetchTake;
  end

  p_fetch_bound_r1: assert property (@(posedge clk) disable iff (!rstN)
    fetchTake <= fetchNum);
  p_lane_not_branch_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stb.laneFire[0] |-> !head[0].isBranch) and (stb.laneFire[1] |-> !head[1].isBranch));
  p_in_order_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.laneFire[1] |-> (stb.laneFire[0] || (stb.brFire && stb.brPos == 2'd0)));
  p_branch_ready_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.brFire |-> (brReady && head[stb.brPos].isBranch));
  p_unit_ready_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.laneFire[0] |-> unitReady[head[0].unit]) and (stb.laneFire[1] |-> unitReady[head[1].unit]));
  p_distinct_units_r5: assert property (@(posedge clk) disable iff (!rstN)
    (&stb.laneFire) |-> (head[0].unit != head[1].unit));
  p_cq_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    {1'b0, cqAllocCount} <= 3'(cqFreeCount));

endmodule

// File: rtl/dispatch_datapath.sv
module dispatch_datapath
  import dispatch_pkg::*;
#(
  parameter int IQ_DEPTH = 8,
  parameter int CQ_DEPTH = 6,
  parameter int DATA_W   = 16,
  parameter int TAG_W    = 3,
  localparam int OCC_W = $clog2(IQ_DEPTH + 1),
  localparam int CQI_W = $clog2(CQ_DEPTH)
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  dispStrobe_t                          stb,
  input  logic [FETCH_W-1:0][REC_W-1:0]        fetchRecs,
  input  logic [CQI_W-1:0]                     cqTail,
  input  logic [NUM_REGS-1:0][DATA_W-1:0]      rfValue,
  input  logic [NUM_REGS-1:0]                  rfPending,
  input  logic [NUM_REGS-1:0][TAG_W-1:0]       rfTag,
  output logic [OCC_W-1:0]                     occ,
  output instRec_t [HEAD_N-1:0]                head,
  output logic [LANES-1:0][1:0]                laneUnit,
  output logic [LANES-1:0][OP_W-1:0]           laneOp,
  output logic [LANES-1:0]                     laneRdyA,
  output logic [LANES-1:0][DATA_W-1:0]         laneValA,
  output logic [LANES-1:0][TAG_W-1:0]          laneTagA,
  output logic [LANES-1:0]                     laneRdyB,
  output logic [LANES-1:0][DATA_W-1:0]         laneValB,
  output logic [LANES-1:0][TAG_W-1:0]          laneTagB,
  output logic [LANES-1:0][CQI_W-1:0]          laneCq,
  output logic [OP_W-1:0]                      brOp,
  output logic                                 brRdyA,
  output logic [DATA_W-1:0]                    brValA,
  output logic [TAG_W-1:0]                     brTagA,
  output logic                                 brRdyB,
  output logic [DATA_W-1:0]                    brValB,
  output logic [TAG_W-1:0]                     brTagB,
  output logic [CQI_W-1:0]                     brCq
);

  instRec_t iq     [IQ_DEPTH];
  instRec_t iqNext [IQ_DEPTH];
  logic [OCC_W-1:0] occNext;

  // Shift out the dispatched head, then drop accepted fetches behind the survivors.
  always_comb begin
    int base;
    int src;
    base = int'(occ) - int'(stb.shiftBy);
    for (int i = 0; i < IQ_DEPTH; i++) begin
      src = i + int'(stb.shiftBy);
      iqNext[i] = (src < IQ_DEPTH) ? iq[src] : '0;
      for (int j = 0; j < FETCH_W; j++) begin
        if ((j < int'(stb.appendBy)) && (i == base + j)) begin
          iqNext[i] = instRec_t'(fetchRecs[j]);
        end
      end
    end
    occNext = OCC_W'(base + int'(stb.appendBy));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      occ <= '0;
      for (int i = 0; i < IQ_DEPTH; i++) iq[i] <= '0;
    end else begin
      occ <= occNext;
      for (int i = 0; i < IQ_DEPTH; i++) iq[i] <= iqNext[i];
    end
  end

  // Per head position: operand read or rename tag, and completion index.
  logic [HEAD_N-1:0]             posRdyA, posRdyB;
  logic [HEAD_N-1:0][DATA_W-1:0] posValA, posValB;
  logic [HEAD_N-1:0][TAG_W-1:0]  posTagA, posTagB;
  logic [HEAD_N-1:0][CQI_W-1:0]  posCq;

  for (genvar p = 0; p < HEAD_N; p++) begin : g_pos
    assign head[p] = iq[p];

    always_comb begin
      int slot;
      posRdyA[p] = !rfPending[iq[p].srcA];
      posValA[p] = posRdyA[p] ? rfValue[iq[p].srcA] : '0;
      posTagA[p] = posRdyA[p] ? '0 : rfTag[iq[p].srcA];
      posRdyB[p] = !rfPending[iq[p].srcB];
      posValB[p] = posRdyB[p] ? rfValue[iq[p].srcB] : '0;
      posTagB[p] = posRdyB[p] ? '0 : rfTag[iq[p].srcB];
      slot = int'(cqTail) + p;
      if (slot >= CQ_DEPTH) slot = slot - CQ_DEPTH;
      posCq[p] = CQI_W'(slot);
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign laneUnit[k] = iq[k].unit;
    assign laneOp[k]   = iq[k].op;
    assign laneRdyA[k] = posRdyA[k];
    assign laneValA[k] = posValA[k];
    assign laneTagA[k] = posTagA[k];
    assign laneRdyB[k] = posRdyB[k];
    assign laneValB[k] = posValB[k];
    assign laneTagB[k] = posTagB[k];
    assign laneCq[k]   = posCq[k];
  end

  assign brOp   = head[stb.brPos].op;
  assign brRdyA = posRdyA[stb.brPos];
  assign brValA = posValA[stb.brPos];
  assign brTagA = posTagA[stb.brPos];
  assign brRdyB = posRdyB[stb.brPos];
  assign brValB = posValB[stb.brPos];
  assign brTagB = posTagB[stb.brPos];
  assign brCq   = posCq[stb.brPos];

  p_occ_bound_r1: assert property (@(posedge clk) disable iff (!rstN)
    int'(occ) <= IQ_DEPTH);
  p_shift_one_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stb.shiftBy == 2'd1 && int'(occ) >= 2) |=> (head[0] == $past(head[1])));
  p_shift_two_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stb.shiftBy == 2'd2 && int'(occ) >= 3) |=> (head[0] == $past(head[2])));
  p_tag_when_pending_r8: assert property (@(posedge clk) disable iff (!rstN)
    !laneRdyA[0] |-> (laneValA[0] == '0));

endmodule

// File: rtl/dual_issue_dispatch.sv
module dual_issue_dispatch
  import dispatch_pkg::*;
#(
  parameter int IQ_DEPTH = 8,
  parameter int CQ_DEPTH = 6,
  parameter int DATA_W   = 16,
  parameter int TAG_W    = 3,
  localparam int OCC_W = $clog2(IQ_DEPTH + 1),
  localparam int CQF_W = $clog2(CQ_DEPTH + 1),
  localparam int CQI_W = $clog2(CQ_DEPTH)
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [FCNT_W-1:0]                 fetchNum,
  input  logic [FETCH_W-1:0][REC_W-1:0]     fetchRecs,
  output logic [FCNT_W-1:0]                 fetchTake,
  input  logic [NUM_UNITS-1:0]              unitReady,
  input  logic                              brReady,
  input  logic [CQF_W-1:0]                  cqFreeCount,
  input  logic [CQI_W-1:0]                  cqTail,
  output logic [1:0]                        cqAllocCount,
  input  logic [NUM_REGS-1:0][DATA_W-1:0]   rfValue,
  input  logic [NUM_REGS-1:0]               rfPending,
  input  logic [NUM_REGS-1:0][TAG_W-1:0]    rfTag,
  output logic [LANES-1:0]                  laneValid,
  output logic [LANES-1:0][1:0]             laneUnit,
  output logic [LANES-1:0][OP_W-1:0]        laneOp,
  output logic [LANES-1:0]                  laneRdyA,
  output logic [LANES-1:0][DATA_W-1:0]      laneValA,
  output logic [LANES-1:0][TAG_W-1:0]       laneTagA,
  output logic [LANES-1:0]                  laneRdyB,
  output logic [LANES-1:0][DATA_W-1:0]      laneValB,
  output logic [LANES-1:0][TAG_W-1:0]       laneTagB,
  output logic [LANES-1:0][CQI_W-1:0]       laneCq,
  output logic                              brValid,
  output logic [OP_W-1:0]                   brOp,
  output logic                              brRdyA,
  output logic [DATA_W-1:0]                 brValA,
  output logic [TAG_W-1:0]                  brTagA,
  output logic                              brRdyB,
  output logic [DATA_W-1:0]                 brValB,
  output logic [TAG_W-1:0]                  brTagB,
  output logic [CQI_W-1:0]                  brCq
);

  dispStrobe_t           stb;
  logic [OCC_W-1:0]      occ;
  instRec_t [HEAD_N-1:0] head;

  dispatch_ctrl #(.IQ_DEPTH(IQ_DEPTH), .CQ_DEPTH(CQ_DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .occ(occ), .head(head), .fetchNum(fetchNum),
    .unitReady(unitReady), .brReady(brReady), .cqFreeCount(cqFreeCount),
    .fetchTake(fetchTake), .cqAllocCount(cqAllocCount), .stb(stb)
  );

  dispatch_datapath #(.IQ_DEPTH(IQ_DEPTH), .CQ_DEPTH(CQ_DEPTH),
                      .DATA_W(DATA_W), .TAG_W(TAG_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .fetchRecs(fetchRecs), .cqTail(cqTail),
    .rfValue(rfValue), .rfPending(rfPending), .rfTag(rfTag),
    .occ(occ), .head(head),
    .laneUnit(laneUnit), .laneOp(laneOp),
    .laneRdyA(laneRdyA), .laneValA(laneValA), .laneTagA(laneTagA),
    .laneRdyB(laneRdyB), .laneValB(laneValB), .laneTagB(laneTagB),
    .laneCq(laneCq), .brOp(brOp),
    .brRdyA(brRdyA), .brValA(brValA), .brTagA(brTagA),
    .brRdyB(brRdyB), .brValB(brValB), .brTagB(brTagB), .brCq(brCq)
  );

  assign laneValid = stb.laneFire;
  assign brValid   = stb.brFire;

  p_reset_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (laneValid == '0 && !brValid));

endmodule

// File: tb/sim_dual_issue_dispatch.sv
`timescale 1ns/1ps
module sim_dual_issue_dispatch;
  import dispatch_pkg::*;

  localparam int DEPTH = 8;
  localparam int CQD   = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic [2:0]               fetchNum = '0;
  logic [3:0][REC_W-1:0]    fetchRecs = '0;
  logic [2:0]               fetchTake;
  logic [3:0]               unitReady = '0;
  logic                     brReady = 1'b0;
  logic [2:0]               cqFreeCount = '0;
  logic [2:0]               cqTail = '0;
  logic [1:0]               cqAllocCount;
  logic [7:0][15:0]         rfValue = '0;
  logic [7:0]               rfPending = '0;
  logic [7:0][2:0]          rfTag = '0;
  logic [1:0]               laneValid;
  logic [1:0][1:0]          laneUnit;
  logic [1:0][7:0]          laneOp;
  logic [1:0]               laneRdyA, laneRdyB;
  logic [1:0][15:0]         laneValA, laneValB;
  logic [1:0][2:0]          laneTagA, laneTagB, laneCq;
  logic                     brValid, brRdyA, brRdyB;
  logic [7:0]               brOp;
  logic [15:0]              brValA, brValB;
  logic [2:0]               brTagA, brTagB, brCq;

  dual_issue_dispatch u0 (
    .clk(clk), .rstN(rstN), .fetchNum(fetchNum), .fetchRecs(fetchRecs),
    .fetchTake(fetchTake), .unitReady(unitReady), .brReady(brReady),
    .cqFreeCount(cqFreeCount), .cqTail(cqTail), .cqAllocCount(cqAllocCount),
    .rfValue(rfValue), .rfPending(rfPending), .rfTag(rfTag),
    .laneValid(laneValid), .laneUnit(laneUnit), .laneOp(laneOp),
    .laneRdyA(laneRdyA), .laneValA(laneValA), .laneTagA(laneTagA),
    .laneRdyB(laneRdyB), .laneValB(laneValB), .laneTagB(laneTagB),
    .laneCq(laneCq), .brValid(brValid), .brOp(brOp),
    .brRdyA(brRdyA), .brValA(brValA), .brTagA(brTagA),
    .brRdyB(brRdyB), .brValB(brValB), .brTagB(brTagB), .brCq(brCq)
  );

  int tests = 0;
  int fails = 0;
  logic [REC_W-1:0] mq[$];
  int knFreeLo = 0, knFreeHi = 6, knReadyPct = 75, knBrPct = 30;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int opnd(input int r);
    // {ready, value, tag} expected for source register r
    if (!rfPending[r]) return (1 << 19) | (int'(rfValue[r]) << 3);
    return int'(rfTag[r]);
  endfunction

  function automatic logic [REC_W-1:0] mkRec();
    logic [REC_W-1:0] r;
    r = REC_W'($urandom);
    r[16] = ($urandom_range(0, 99) < knBrPct);
    return r;
  endfunction

  task automatic step();
    int took, sz, expTake;
    bit halt, brSeen;
    bit [3:0] used;
    bit expLane[2];
    int expBrPos;
    bit expBr;
    logic [REC_W-1:0] rec;
    @(negedge clk);
    fetchNum = 3'($urandom_range(0, 4));
    for (int j = 0; j < 4; j++) fetchRecs[j] = mkRec();
    for (int u = 0; u < 4; u++) unitReady[u] = ($urandom_range(0, 99) < knReadyPct);
    brReady = ($urandom_range(0, 99) < knReadyPct);
    cqFreeCount = 3'($urandom_range(knFreeLo, knFreeHi));
    cqTail = 3'($urandom_range(0, CQD - 1));
    for (int r = 0; r < 8; r++) begin
      rfValue[r] = 16'($urandom);
      rfPending[r] = $urandom_range(0, 1);
      rfTag[r] = 3'($urandom);
    end
    #1;
    sz = mq.size();
    took = 0; halt = 0; brSeen = 0; used = '0;
    expLane[0] = 0; expLane[1] = 0; expBr = 0; expBrPos = 0;
    for (int p = 0; p < 3; p++) begin
      bit ok;
      rec = (p < sz) ? mq[p] : '0;
      ok = !halt && (p < sz) && (took < int'(cqFreeCount));
      if (rec[16]) ok = ok && !brSeen && brReady;
      else ok = ok && (p < 2) && unitReady[rec[15:14]] && !used[rec[15:14]];
      if (ok) begin
        took++;
        if (rec[16]) begin brSeen = 1; expBr = 1; expBrPos = p; end
        else begin used[rec[15:14]] = 1; expLane[p] = 1; end
      end else halt = 1;
    end
    expTake = (int'(fetchNum) < DEPTH - sz) ? int'(fetchNum) : DEPTH - sz;
    chk(int'(fetchTake) == expTake, "R1", "fetchTake", int'(fetchTake), expTake);
    chk(int'(cqAllocCount) == took && took <= int'(cqFreeCount), "R6", "cqAllocCount",
        int'(cqAllocCount), took);
    for (int k = 0; k < 2; k++) begin
      chk(laneValid[k] == expLane[k], k == 0 ? "R2" : "R3", "laneValid",
          int'(laneValid[k]), int'(expLane[k]));
      if (expLane[k] && laneValid[k]) begin
        rec = mq[k];
        chk({laneUnit[k], laneOp[k]} == rec[15:6], "R5", "lane unit/op",
            int'({laneUnit[k], laneOp[k]}), int'(rec[15:6]));
        chk(int'({laneRdyA[k], laneValA[k], laneTagA[k]}) == opnd(int'(rec[5:3])), "R8",
            "lane srcA", int'({laneRdyA[k], laneValA[k], laneTagA[k]}), opnd(int'(rec[5:3])));
        chk(int'({laneRdyB[k], laneValB[k], laneTagB[k]}) == opnd(int'(rec[2:0])), "R8",
            "lane srcB", int'({laneRdyB[k], laneValB[k], laneTagB[k]}), opnd(int'(rec[2:0])));
        chk(int'(laneCq[k]) == (int'(cqTail) + k) % CQD, "R7", "laneCq",
            int'(laneCq[k]), (int'(cqTail) + k) % CQD);
      end
    end
    chk(brValid == expBr, "R4", "brValid", int'(brValid), int'(expBr));
    if (expBr && brValid) begin
      rec = mq[expBrPos];
      chk(brOp == rec[13:6], "R4", "brOp", int'(brOp), int'(rec[13:6]));
      chk(int'({brRdyA, brValA, brTagA}) == opnd(int'(rec[5:3])), "R8", "br srcA",
          int'({brRdyA, brValA, brTagA}), opnd(int'(rec[5:3])));
      chk(int'({brRdyB, brValB, brTagB}) == opnd(int'(rec[2:0])), "R8", "br srcB",
          int'({brRdyB, brValB, brTagB}), opnd(int'(rec[2:0])));
      chk(int'(brCq) == (int'(cqTail) + expBrPos) % CQD, "R7", "brCq",
          int'(brCq), (int'(cqTail) + expBrPos) % CQD);
    end
    @(posedge clk);
    // R10: survivors keep order after the shift
    for (int i = 0; i < took; i++) void'(mq.pop_front());
    for (int j = 0; j < expTake; j++) mq.push_back(fetchRecs[j]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    fetchNum = 3'd4; cqFreeCount = 3'd6; unitReady = 4'hF; brReady = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R9: empty after reset, whole group accepted, nothing dispatched
    chk(laneValid == 2'b00, "R9", "laneValid after reset", int'(laneValid), 0);
    chk(!brValid, "R9", "brValid after reset", int'(brValid), 0);
    chk(fetchTake == 3'd4, "R9", "fetchTake after reset", int'(fetchTake), 4);
    fetchNum = 3'd0;
    @(posedge clk);
    repeat (200) step();
    knFreeLo = 0; knFreeHi = 0;           // fill queue to the brim (R1 boundary)
    repeat (30) step();
    knFreeLo = 6; knFreeHi = 6; knReadyPct = 100;   // triple-dispatch pressure
    repeat (200) step();
    knFreeLo = 1; knFreeHi = 2; knReadyPct = 80;    // completion-slot limited
    repeat (150) step();
    knFreeLo = 0; knFreeHi = 6; knReadyPct = 50; knBrPct = 50;
    repeat (300) step();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule